// File: doc/BRIEF.md
# Accumulator Operate and Shift Unit

This block holds a 16-bit accumulator and a 1-bit link. It executes two instruction groups, one instruction per start strobe. The first is the operate microinstructions, whose bits clear, complement, increment or merge the accumulator and link. The second is the rotate and arithmetic-shift group. The word is presented on `instr` together with `go`. The result is written on the next rising clock edge.

Operate bits are applied in three ordered phases, so that combined bits compose predictably. Phase one clears. Phase two complements. Phase three increments and then ORs in the data switches. A halt word stops the unit. An illegal shift count stops it with an error indication. Once stopped, the unit ignores strobes until reset. Words outside the two groups leave every register as it was.

Top module: `acc_opshift`

## Requirements
- R1: After reset the accumulator and link are 0, `running` is 1, and `halt` and `err` are 0.
- R2: An operate word is one with bits 14..6 all zero. In phase one, bit 0 clears the accumulator and bit 3 clears the link.
- R3: In phase two, which acts on the phase-one result, bit 1 complements the accumulator and bit 4 complements the link.
- R4: In phase three, bit 2 adds one to the accumulator and toggles the link on a carry out of bit 15. After that, bit 5 ORs `switches` into the accumulator.
- R5: An operate word with bits 5..0 all zero and bit 15 clear is a halt. It drops `running`, pulses `halt` high for one cycle, and leaves the accumulator and link unchanged.
- R6: An operate word with bits 5..0 all zero and bit 15 set changes nothing.
- R7: A shift-group word has bits 15..6 equal to 24, bits 3..2 zero, and a count of 1 to 3 in bits 1..0. Bits 5..4 select the operation: 0 rotates left, 1 rotates right. Rotates act on the 16 accumulator bits alone, and the link is unchanged by every shift.
- R8: When bits 5..4 are 2, the word is an arithmetic left shift. It keeps bit 15 and shifts bits 14..0 left by the count. Bits moved past bit 14 are lost and zeros fill from the right.
- R9: When bits 5..4 are 3, the word is an arithmetic right shift by the count, and it copies bit 15 into the vacated bits.
- R10: A shift-group word whose count is 0, or whose bits 3..2 are not zero, sets `err` and drops `running`. The accumulator and link are unchanged.
- R11: While `running` is 0, while `go` is low, or for a word in neither group, the accumulator, link and `running` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Execute `instr` on this edge |
| instr | input | 16 | Instruction word |
| switches | input | 16 | Data switch value for the OR operation |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| running | output | 1 | Unit accepts strobes |
| halt | output | 1 | One-cycle pulse on a halt word |
| err | output | 1 | Sticky flag for an illegal shift code |

## Verification
The assertions assume that `go` and `instr` are stable around the rising edge and that reset is synchronous. They also assume that `running` can only be raised again by reset, so a strobe after a halt or an error is legal input that must have no effect. The bench drives every input on the falling edge. It pulses `go` for exactly one cycle per word. It resets the unit after each halt or error, which keeps each random sequence in the running state, where the model applies.

// File: rtl/acc_opshift.sv
module acc_opshift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [15:0]  instr,
  input  logic [W-1:0] switches,
  output logic [W-1:0] acc,
  output logic         link,
  output logic         running,
  output logic         halt,
  output logic         err
);
  localparam int SW = $clog2(W) + 1;

  logic is_opr, is_shf, shf_ok, is_halt;
  logic [1:0] sh_n;
  logic [SW-1:0] rsh;

  assign is_opr  = instr[14:6] == 9'd0;
  assign is_shf  = instr[15:6] == 10'd24;
  assign sh_n    = instr[1:0];
  assign shf_ok  = instr[3:2] == 2'b00 && sh_n != 2'd0;
  assign is_halt = instr[5:0] == 6'd0 && !instr[15];
  assign rsh     = SW'(W) - SW'(sh_n);

  // operate phases
  logic [W-1:0] ac1, ac2, ac3, ac4;
  logic l1, l2, l3, cy;
  assign ac1 = instr[0] ? '0 : acc;
  assign l1  = instr[3] ? 1'b0 : link;
  assign ac2 = instr[1] ? ~ac1 : ac1;
  assign l2  = l1 ^ instr[4];
  assign {cy, ac3} = {1'b0, ac2} + (W+1)'(instr[2]);
  assign l3  = l2 ^ cy;
  assign ac4 = ac3 | (instr[5] ? switches : '0);

  // rotate / shift
  logic [W-1:0] shv;
  always_comb begin
    case (instr[5:4])
      2'd0:    shv = (acc << sh_n) | (acc >> rsh);
      2'd1:    shv = (acc >> sh_n) | (acc << rsh);
      2'd2:    shv = {acc[W-1], acc[W-2:0] << sh_n};
      default: shv = $unsigned($signed(acc) >>> sh_n);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      link <= 1'b0;
      running <= 1'b1;
      halt <= 1'b0;
      err <= 1'b0;
    end else begin
      halt <= 1'b0;
      if (go && running) begin
        if (is_opr) begin
          if (is_halt) begin
            running <= 1'b0;
            halt <= 1'b1;
          end else begin
            acc <= ac4;
            link <= l3;
          end
        end else if (is_shf) begin
          if (shf_ok) acc <= shv;
          else begin
            err <= 1'b1;
            running <= 1'b0;
          end
        end
      end
    end
  end

  assert_halt_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> $fell(running) && $stable(acc) && $stable(link));

  assert_err_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !running);

  assert_shift_keeps_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && running && instr[15:6] == 10'd24) |=> $stable(link));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !running && $stable(acc) && $stable(link));

  assert_nogo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(acc) && $stable(link) && $stable(running));
endmodule

// File: tb/acc_opshift_bench.sv
module acc_opshift_bench;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [15:0] instr = '0, switches = '0;
  logic [15:0] acc;
  logic link, running, halt, err;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_acc;
  logic m_link;

  always #5 clk = ~clk;

  acc_opshift u_acc_opshift (.clk(clk), .rst_n(rst_n), .go(go), .instr(instr),
    .switches(switches), .acc(acc), .link(link), .running(running),
    .halt(halt), .err(err));

  // returns {halt, err, link, acc}
  function automatic logic [18:0] model(logic [15:0] w, logic [15:0] a, logic l, logic [15:0] s);
    logic [16:0] t;
    int n;
    if (w[14:6] == 0) begin
      if (w[5:0] == 0) return {!w[15], 1'b0, l, a};
      if (w[0]) a = 0;
      if (w[3]) l = 0;
      if (w[1]) a = ~a;
      if (w[4]) l = ~l;
      if (w[2]) begin t = {1'b0, a} + 17'd1; a = t[15:0]; if (t[16]) l = ~l; end
      if (w[5]) a = a | s;
      return {2'b00, l, a};
    end
    if (w[15:6] == 24) begin
      n = int'(w[1:0]);
      if (w[3:2] != 0 || n == 0) return {2'b01, l, a};
      for (int i = 0; i < n; i++)
        case (w[5:4])
          2'd0: a = {a[14:0], a[15]};
          2'd1: a = {a[0], a[15:1]};
          2'd2: a = {a[15], a[13:0], 1'b0};
          default: a = {a[15], a[15:1]};
        endcase
      return {2'b00, l, a};
    end
    return {2'b00, l, a};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; go = 0;
    @(negedge clk); rst_n = 1;
    m_acc = 0; m_link = 0;
  endtask

  task automatic step(logic [15:0] w, logic [15:0] s);
    @(negedge clk); go = 1; instr = w; switches = s;
    @(negedge clk); go = 0;
  endtask

  task automatic exec(string tag, logic [15:0] w, logic [15:0] s);
    logic [18:0] r;
    r = model(w, m_acc, m_link, s);
    step(w, s);
    m_acc = r[15:0]; m_link = r[16];
    chk({tag, " acc"}, {16'd0, acc}, {16'd0, m_acc});
    chk({tag, " link"}, {31'd0, link}, {31'd0, m_link});
    chk({tag, " run"}, {31'd0, running}, {31'd0, !(r[18] | r[17])});
  endtask

  function automatic logic [15:0] rand_word();
    logic [15:0] w;
    int k;
    k = $urandom_range(0, 9);
    if (k < 5) begin
      w = {1'($urandom()), 9'd0, 6'($urandom())};
      if (w[5:0] == 0) w[15] = 1'b1;
    end else if (k < 9) begin
      w = {10'd24, 2'($urandom()), 2'b00, 2'($urandom_range(1, 3))};
    end else begin
      w = {1'($urandom()), 4'b0100, 11'($urandom())};
    end
    return w;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 acc", {16'd0, acc}, 0);
    chk("R1 flags", {28'd0, link, running, halt, err}, 32'b0100);

    exec("R2 load", 16'o100041, 16'hC001);
    chk("R2 load value", {16'd0, acc}, 32'hC001);
    exec("R3 cla+cma+cml", 16'o100023, 16'h0);
    chk("R3 all ones", {15'd0, link, acc}, 32'h1FFFF);
    exec("R4 iac carry", 16'o100004, 16'h0);
    chk("R4 wrap link", {15'd0, link, acc}, 32'h00000);
    exec("R4 iac then or", 16'o100045, 16'h00F0);
    chk("R4 or after inc", {16'd0, acc}, 32'h00F1);
    exec("R2 cll", 16'o100010, 16'h0);
    exec("R8 load", 16'o100041, 16'hC001);
    exec("R8 sal3", 16'o003043, 16'h0);
    chk("R8 keeps sign", {16'd0, acc}, 32'h8008);
    exec("R9 load", 16'o100041, 16'h8000);
    exec("R9 sar2", 16'o003062, 16'h0);
    chk("R9 sign fill", {16'd0, acc}, 32'hE000);
    exec("R7 load", 16'o100041, 16'h8001);
    exec("R7 stl", 16'o100030, 16'h0);
    exec("R7 rol1", 16'o003001, 16'h0);
    chk("R7 rol value", {15'd0, link, acc}, 32'h10003);
    exec("R7 ror3", 16'o003023, 16'h0);
    chk("R7 ror value", {15'd0, link, acc}, 32'h16000);
    exec("R6 nop", 16'o100000, 16'hFFFF);
    chk("R6 nop unchanged", {15'd0, link, acc}, 32'h16000);
    exec("R11 other word", 16'o020010, 16'hFFFF);
    chk("R11 other unchanged", {15'd0, link, acc}, 32'h16000);

    for (int i = 0; i < 400; i++) exec("R2-7 random", rand_word(), 16'($urandom()));

    step(16'o003000, 16'h0);
    chk("R10 err set", {30'd0, err, running}, 32'b10);
    chk("R10 acc kept", {15'd0, link, acc}, {15'd0, m_link, m_acc});
    step(16'o100001, 16'h0);
    chk("R11 stopped ignores", {15'd0, link, acc}, {15'd0, m_link, m_acc});
    do_reset();
    exec("R10 load", 16'o100041, 16'h1234);
    step(16'o003044, 16'h0);
    chk("R10 bad bit2", {30'd0, err, running}, 32'b10);
    do_reset();
    exec("R5 load", 16'o100041, 16'h00AA);
    step(16'o000000, 16'h0);
    chk("R5 halt pulse", {29'd0, running, halt, err}, 32'b010);
    chk("R5 acc kept", {16'd0, acc}, 32'h00AA);
    @(negedge clk);
    chk("R5 pulse ends", {31'd0, halt}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule